// File: doc/BRIEF.md
# Four-Mode Serial Port with Address Filtering

This block is a byte-oriented serial port with one 8-bit control/status register and one data buffer, both on a small register bus. Two mode bits select one of four framings. Mode 0 is a clocked shift-out of eight bits with a companion clock pin. Mode 1 is an asynchronous frame of ten bits: a start bit, eight data bits and a stop bit. Modes 2 and 3 are eleven-bit frames that carry a ninth data bit. Modes 1 and 3 time their bits from an external 16x baud tick. Mode 2 makes its own 16x tick by dividing the core clock by 2 or by 4, which is 1/32 or 1/64 of the clock per bit.

Software starts a transmission by writing the data buffer. It reads received bytes back from the same address. Two flags report progress: TI marks the end of transmission and RI marks a received frame. Hardware only ever sets these flags, and software clears them by writing the control register. A filter bit lets a node in a multidrop network accept only frames whose ninth bit is 1, which are address frames, or in mode 1 only frames with a valid stop bit. An external select input changes the meaning of control bit 7: it is either a mode bit or a sticky framing-error flag.

Top module: `sio_port`

## Requirements
- R1: After a synchronous reset the control register and the data buffer read 0x00, `txd` is 1 and `sclk` is 1.
- R2: Address 0 is the control register, with bits [7:0] = {bit7, SM1, SM2, REN, TB8, RB8, TI, RI}. Address 1 is the data buffer. `bus_rdata` is registered and shows the selected register one cycle after the address is presented. Bit 7 reads and writes the framing-error flag when `fe_sel`=1. When `fe_sel`=0, bit 7 reads and writes SM0. The mode is {SM0,SM1}.
- R3: In mode 0, a data write sends the eight bits LSB first on `txd`. Each bit lasts SHIFT_DIV (12) clocks. `sclk` is low for the first half of each bit and high for the second half. TI is set after the eighth bit.
- R4: In modes 1 to 3, a data write sends a frame on `txd`: a start bit of 0, eight data bits LSB first, then TB8 (modes 2 and 3 only), then a stop bit of 1. Each bit lasts 16 ticks. In mode 1, TB8 has no effect on the line.
- R5: Modes 1 and 3 count `baud_tick`. Mode 2 ticks on every 2nd clock when `rate_dbl`=1 and on every 4th clock when `rate_dbl`=0. The tick phase is counted from reset.
- R6: In the asynchronous modes, TI is set at the start of the stop bit. A data write while a frame is going out is ignored. Writing 0 to TI clears it.
- R7: With REN=1 in modes 1 to 3, a low level on `rxd` starts reception. Each bit is decided by a majority vote of three samples taken 8, 9 and 10 ticks into the bit. A start bit that votes 1 is dropped without effect.
- R8: On an accepted frame, RB8 takes the stop bit in mode 1 and the ninth data bit in modes 2 and 3.
- R9: With SM2=1, a frame is accepted in modes 2 and 3 only when its ninth bit is 1, and in mode 1 only when its stop bit is 1. A frame that is not accepted leaves RI, RB8 and the buffer unchanged.
- R10: A frame that ends while RI is 1 leaves the buffer, RB8 and RI unchanged.
- R11: A stop bit received as 0 sets the framing-error flag, whatever the state of SM2 and RI. Only a software write clears the flag. Later valid frames leave it set.
- R12: With REN=0, activity on `rxd` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control register, 1 = data buffer |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| fe_sel | input | 1 | Selects bit 7 as the framing-error flag (1) or SM0 (0) |
| rate_dbl | input | 1 | Mode 2 rate select: 1 for clock/32, 0 for clock/64 |
| baud_tick | input | 1 | 16x bit-rate strobe for modes 1 and 3 |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, also the mode 0 data line |
| sclk | output | 1 | Mode 0 shift clock, high when idle |

## Verification
A wrong bit or sub-bit counter in the transmitter shows on `txd` or `sclk` at the very next bit boundary, so the line is compared with a model on every clock. A wrong TI timing shows up when the register is read one bit before the stop bit and again one bit into it. Receiver faults only appear after a frame completes, in RI, RB8, the framing-error flag or the buffer. Glitches placed inside the three-sample window separate a true majority vote from a single sample. Frames with a filtered ninth bit, a bad stop bit, RI still set, or REN clear check that the state left behind stays unchanged.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DATA_W = 8;
  localparam int CTRL_W = 8;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'b00,
    MODE_UART8  = 2'b01,
    MODE_UART9F = 2'b10,
    MODE_UART9V = 2'b11
  } sio_mode_e;
endpackage

// File: rtl/sio_tick_gen.sv
module sio_tick_gen
  import sio_pkg::*;
#(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  sio_mode_e mode,
  input  logic      rate_dbl,
  input  logic      baud_tick,
  output logic      tick
);
  localparam int CW = $clog2(SLOW_DIV);

  logic [CW-1:0] cnt;
  logic          fast_hit, slow_hit;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign fast_hit = ((cnt & CW'(FAST_DIV - 1)) == CW'(FAST_DIV - 1));
  assign slow_hit = (cnt == CW'(SLOW_DIV - 1));

  always_comb begin
    if (mode == MODE_UART9F) tick = rate_dbl ? fast_hit : slow_hit;
    else                     tick = baud_tick;
  end

  // R5: the internal rate never produces back-to-back ticks
  p_fixed_tick_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_UART9F && tick) |=> !(mode == MODE_UART9F && tick));
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int SHIFT_DIV  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  sio_mode_e         mode,
  input  logic              tick,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  logic              ninth,
  output logic              txd,
  output logic              sclk,
  output logic              ti_set
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int IDX_W   = $clog2(FRAME_W + 1);
  localparam int SUB_W   = $clog2(OVERSAMPLE);
  localparam int DIV_W   = $clog2(SHIFT_DIV);
  localparam int HALF    = SHIFT_DIV / 2;

  logic               busy, shift_m;
  logic [FRAME_W-1:0] frame;
  logic [IDX_W-1:0]   idx, last_idx, nxt_idx;
  logic [SUB_W-1:0]   sub;
  logic [DIV_W-1:0]   div;

  assign nxt_idx = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      shift_m  <= 1'b0;
      frame    <= '1;
      idx      <= '0;
      last_idx <= '0;
      sub      <= '0;
      div      <= '0;
      txd      <= 1'b1;
      sclk     <= 1'b1;
      ti_set   <= 1'b0;
    end else begin
      ti_set <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          idx  <= '0;
          sub  <= '0;
          div  <= '0;
          if (mode == MODE_SHIFT) begin
            shift_m  <= 1'b1;
            frame    <= {3'b111, data};
            last_idx <= IDX_W'(DATA_W - 1);
            txd      <= data[0];
            sclk     <= 1'b0;
          end else begin
            shift_m <= 1'b0;
            sclk    <= 1'b1;
            txd     <= 1'b0;
            if (mode == MODE_UART8) begin
              frame    <= {2'b11, data, 1'b0};
              last_idx <= IDX_W'(DATA_W + 1);
            end else begin
              frame    <= {1'b1, ninth, data, 1'b0};
              last_idx <= IDX_W'(DATA_W + 2);
            end
          end
        end
      end else if (shift_m) begin
        if (div == DIV_W'(HALF - 1)) sclk <= 1'b1;
        if (div == DIV_W'(SHIFT_DIV - 1)) begin
          div <= '0;
          if (idx == last_idx) begin
            busy   <= 1'b0;
            txd    <= 1'b1;
            sclk   <= 1'b1;
            ti_set <= 1'b1;
          end else begin
            idx  <= nxt_idx;
            txd  <= frame[nxt_idx];
            sclk <= 1'b0;
          end
        end else begin
          div <= div + 1'b1;
        end
      end else if (tick) begin
        if (sub == SUB_W'(OVERSAMPLE - 1)) begin
          sub <= '0;
          if (idx == last_idx) begin
            busy <= 1'b0;
            txd  <= 1'b1;
          end else begin
            idx <= nxt_idx;
            txd <= frame[nxt_idx];
            if (nxt_idx == last_idx) ti_set <= 1'b1;
          end
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  // R1/R4: an idle transmitter holds both lines high
  p_idle_lines_r4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (txd && sclk));
  // R6: the done strobe lasts exactly one cycle
  p_ti_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    ti_set |=> !ti_set);
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  sio_mode_e         mode,
  input  logic              tick,
  input  logic              ren,
  input  logic              rxd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              ninth,
  output logic              stop_bit
);
  localparam int IDX_W = $clog2(DATA_W + 3);
  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam int MID   = OVERSAMPLE / 2;

  logic              rx_m, rx_s, busy, nine, vote, enable;
  logic [1:0]        smp;
  logic [IDX_W-1:0]  idx, last_idx;
  logic [SUB_W-1:0]  sub;
  logic [DATA_W:0]   sreg;

  assign enable   = ren && (mode != MODE_SHIFT);
  assign vote     = (smp[1] & smp[0]) | (smp[1] & rx_s) | (smp[0] & rx_s);
  assign last_idx = nine ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_m     <= 1'b1;
      rx_s     <= 1'b1;
      busy     <= 1'b0;
      nine     <= 1'b0;
      smp      <= '0;
      idx      <= '0;
      sub      <= '0;
      sreg     <= '0;
      done     <= 1'b0;
      data     <= '0;
      ninth    <= 1'b0;
      stop_bit <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
      done <= 1'b0;
      if (!enable) begin
        busy <= 1'b0;
      end else if (!busy) begin
        if (tick && !rx_s) begin
          busy <= 1'b1;
          sub  <= '0;
          idx  <= '0;
          nine <= (mode != MODE_UART8);
        end
      end else if (tick) begin
        sub <= (sub == SUB_W'(OVERSAMPLE - 1)) ? '0 : sub + 1'b1;
        if (sub == SUB_W'(MID - 1) || sub == SUB_W'(MID)) smp <= {smp[0], rx_s};
        if (sub == SUB_W'(MID + 1)) begin
          idx <= idx + 1'b1;
          if (idx == '0) begin
            if (vote) busy <= 1'b0;
          end else if (idx == last_idx) begin
            busy     <= 1'b0;
            done     <= 1'b1;
            stop_bit <= vote;
            data     <= sreg[DATA_W-1:0];
            ninth    <= nine & sreg[DATA_W];
          end else begin
            sreg[IDX_W'(idx - 1'b1)] <= vote;
          end
        end
      end
    end
  end

  // R12: a disabled receiver is idle on the following cycle
  p_rx_off_r12: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !busy);
  // R7: one completion strobe per frame
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int SHIFT_DIV  = 12,
  parameter int FAST_DIV   = 2,
  parameter int SLOW_DIV   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [CTRL_W-1:0] bus_rdata,
  input  logic              fe_sel,
  input  logic              rate_dbl,
  input  logic              baud_tick,
  input  logic              rxd,
  output logic              txd,
  output logic              sclk
);
  logic sm0, sm1, sm2, ren, tb8, rb8, ti, ri, fe;
  logic [DATA_W-1:0] rx_buf, rx_data;
  logic tick, ti_set, rx_done, rx_b9, rx_stop;
  logic wr_ctrl, wr_data, qual, accept, rb8_new;
  logic [CTRL_W-1:0] ctrl_view;
  sio_mode_e mode;

  assign mode      = sio_mode_e'({sm0, sm1});
  assign wr_ctrl   = bus_we && (bus_addr == ADDR_CTRL);
  assign wr_data   = bus_we && (bus_addr == ADDR_DATA);
  assign ctrl_view = {(fe_sel ? fe : sm0), sm1, sm2, ren, tb8, rb8, ti, ri};
  assign rb8_new   = (mode == MODE_UART8) ? rx_stop : rx_b9;
  assign qual      = rb8_new;
  assign accept    = rx_done && !ri && (!sm2 || qual);

  sio_tick_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
    .clk(clk), .rst(rst), .mode(mode), .rate_dbl(rate_dbl),
    .baud_tick(baud_tick), .tick(tick));

  sio_tx #(.OVERSAMPLE(OVERSAMPLE), .SHIFT_DIV(SHIFT_DIV)) u_tx (
    .clk(clk), .rst(rst), .mode(mode), .tick(tick), .start(wr_data),
    .data(bus_wdata[DATA_W-1:0]), .ninth(tb8), .txd(txd), .sclk(sclk),
    .ti_set(ti_set));

  sio_rx #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
    .clk(clk), .rst(rst), .mode(mode), .tick(tick), .ren(ren), .rxd(rxd),
    .done(rx_done), .data(rx_data), .ninth(rx_b9), .stop_bit(rx_stop));

  always_ff @(posedge clk) begin
    if (rst) begin
      {sm0, sm1, sm2, ren, tb8, rb8, ti, ri, fe} <= '0;
      rx_buf    <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctrl) begin
        if (fe_sel) fe  <= bus_wdata[7];
        else        sm0 <= bus_wdata[7];
        {sm1, sm2, ren, tb8, rb8, ti, ri} <= bus_wdata[6:0];
      end
      if (ti_set) ti <= 1'b1;
      if (accept) begin
        ri     <= 1'b1;
        rb8    <= rb8_new;
        rx_buf <= rx_data;
      end
      if (rx_done && !rx_stop) fe <= 1'b1;
      bus_rdata <= (bus_addr == ADDR_DATA) ? rx_buf : ctrl_view;
    end
  end

  // R11: the error flag only drops through a software write
  p_fe_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (fe && !(wr_ctrl && fe_sel)) |=> fe);
  // R10: a pending RI protects the buffer
  p_buf_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (ri && !wr_ctrl) |=> $stable(rx_buf));
  // R9: filtered data frames in the nine-bit modes leave RI alone
  p_filter_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_done && sm2 && mode != MODE_UART8 && !rx_b9 && !wr_ctrl) |=> $stable(ri));
endmodule

// File: tb/tb_sio_port.sv
module tb_sio_port;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_we = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00, rd_val;
  logic [7:0] bus_rdata;
  logic fe_sel = 1'b0, rate_dbl = 1'b0, baud_tick = 1'b1, rxd = 1'b1;
  logic txd, sclk;
  int checks = 0, failures = 0, wd = 0, tick_div = 1, tcnt = 0;

  // reference model state
  int cyc = 0, msub = 0;
  bit m_busy = 0, m_shift = 0, m_tb8 = 0, exp_txd = 1, exp_sclk = 1;
  bit [1:0] m_mode = 2'b00;
  bit [1:0] mq[$];
  bit bq[$];

  always #2.5 clk = ~clk;

  sio_port dut (.clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fe_sel(fe_sel),
    .rate_dbl(rate_dbl), .baud_tick(baud_tick), .rxd(rxd), .txd(txd), .sclk(sclk));

  always @(negedge clk) begin
    tcnt++;
    baud_tick = (tcnt % tick_div == 0);
  end

  // behavioural line model, advanced on every rising edge
  always @(posedge clk) begin
    bit tk;
    if (rst) begin
      cyc = 0; m_busy = 0; exp_txd = 1; exp_sclk = 1; m_mode = 0; m_tb8 = 0;
      mq.delete(); bq.delete();
    end else begin
      if (m_mode == 2'b10) tk = rate_dbl ? (cyc % 2 == 1) : (cyc % 4 == 3);
      else tk = baud_tick;
      cyc++;
      if (!m_busy) begin
        if (bus_we && bus_addr) begin
          m_busy = 1;
          if (m_mode == 2'b00) begin
            m_shift = 1;
            for (int i = 0; i < 8; i++)
              for (int c = 0; c < 12; c++) mq.push_back({bus_wdata[i], (c >= 6) ? 1'b1 : 1'b0});
            {exp_txd, exp_sclk} = mq.pop_front();
          end else begin
            m_shift = 0; msub = 0; exp_sclk = 1;
            bq.push_back(1'b0);
            for (int i = 0; i < 8; i++) bq.push_back(bus_wdata[i]);
            if (m_mode != 2'b01) bq.push_back(m_tb8);
            bq.push_back(1'b1);
            exp_txd = bq.pop_front();
          end
        end
      end else if (m_shift) begin
        if (mq.size() == 0) begin m_busy = 0; exp_txd = 1; exp_sclk = 1; end
        else {exp_txd, exp_sclk} = mq.pop_front();
      end else if (tk) begin
        msub++;
        if (msub == 16) begin
          msub = 0;
          if (bq.size() == 0) begin m_busy = 0; exp_txd = 1; end
          else exp_txd = bq.pop_front();
        end
      end
      if (bus_we && !bus_addr) begin
        if (!fe_sel) m_mode[1] = bus_wdata[7];
        m_mode[0] = bus_wdata[6];
        m_tb8 = bus_wdata[3];
      end
    end
  end

  // line compare on every clock (R3 mode 0 lines, R4/R5 frames)
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (txd !== exp_txd || sclk !== exp_sclk) begin
        failures++;
        $display("FAIL R3/R4 line t=%0t txd=%b sclk=%b expected txd=%b sclk=%b",
                 $time, txd, sclk, exp_txd, exp_sclk);
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0; bus_addr = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); bus_addr = a;
    @(negedge clk); v = bus_rdata; bus_addr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // frame on rxd with 16 clocks per bit; gcnt samples of bit gbit inverted from offset 9
  task automatic send_rx(input logic [7:0] d, input bit nine, input bit b9,
                         input bit stopv, input int gbit, input int gcnt);
    bit fb[$];
    fb.push_back(1'b0);
    for (int i = 0; i < 8; i++) fb.push_back(d[i]);
    if (nine) fb.push_back(b9);
    fb.push_back(stopv);
    for (int j = 0; j < fb.size(); j++)
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        rxd = fb[j] ^ ((j == gbit && c >= 9 && c < 9 + gcnt) ? 1'b1 : 1'b0);
      end
    @(negedge clk); rxd = 1;
    idle(20);
  endtask

  initial begin
    idle(5);
    rst = 0;
    idle(2);
    // R1 reset state
    rd(0, rd_val); chk("R1 ctrl after reset", rd_val, 8'h00);
    rd(1, rd_val); chk("R1 buffer after reset", rd_val, 8'h00);
    chk("R1 idle lines", {6'd0, txd, sclk}, 8'h03);

    // R3 mode 0 shift-out
    wr(0, 8'h00); wr(1, 8'h5A); idle(110);
    rd(0, rd_val); chk("R3 TI after eighth bit", rd_val, 8'h02);
    wr(0, 8'h00);
    rd(0, rd_val); chk("R6 TI cleared by write", rd_val, 8'h00);

    // R4 mode 1 with TB8 set, busy write ignored (R6)
    wr(0, 8'h48); wr(1, 8'hC3); idle(30);
    wr(1, 8'hFF); idle(150);
    rd(0, rd_val); chk("R4 mode 1 done", rd_val, 8'h4A);

    // R4/R5 mode 1 with a sparse baud tick
    tick_div = 3; wr(0, 8'h40); wr(1, 8'h6E); idle(10 * 48 + 20); tick_div = 1;

    // R6 TI timing in mode 3 (stop bit begins 160 clocks after the write)
    wr(0, 8'hC8); wr(1, 8'h81); idle(150);
    rd(0, rd_val); chk("R6 TI clear before stop bit", rd_val, 8'hC8);
    idle(12);
    rd(0, rd_val); chk("R6 TI set in stop bit", rd_val, 8'hCA);
    idle(30);

    // R5 mode 2 at both rates
    rate_dbl = 0; wr(0, 8'h80); wr(1, 8'h3C); idle(11 * 64 + 20);
    rd(0, rd_val); chk("R5 mode 2 slow done", rd_val, 8'h82);
    rate_dbl = 1; wr(0, 8'h88); wr(1, 8'h96); idle(11 * 32 + 20);
    rd(0, rd_val); chk("R5 mode 2 fast done", rd_val, 8'h8A);

    // R7/R8 mode 1 reception
    wr(0, 8'h50); send_rx(8'hA5, 0, 0, 1, -1, 0);
    rd(0, rd_val); chk("R8 RB8 holds stop bit, RI set", rd_val, 8'h55);
    rd(1, rd_val); chk("R7 received byte", rd_val, 8'hA5);

    // R10 RI still set: buffer protected
    send_rx(8'h11, 0, 0, 1, -1, 0);
    rd(1, rd_val); chk("R10 buffer kept while RI set", rd_val, 8'hA5);

    // R7 majority vote (bit 2 of data is frame bit 3)
    wr(0, 8'h50); send_rx(8'h0F, 0, 0, 1, 3, 1);
    rd(1, rd_val); chk("R7 single bad sample outvoted", rd_val, 8'h0F);
    wr(0, 8'h50); send_rx(8'h0F, 0, 0, 1, 3, 2);
    rd(1, rd_val); chk("R7 two bad samples win", rd_val, 8'h0B);

    // R7 false start
    wr(0, 8'h50);
    @(negedge clk); rxd = 0; idle(4); rxd = 1; idle(40);
    rd(0, rd_val); chk("R7 false start dropped", rd_val, 8'h50);

    // R11 framing error, sticky across a valid frame; R2 bit 7 view
    fe_sel = 1; wr(0, 8'h50); send_rx(8'h77, 0, 0, 0, -1, 0);
    rd(0, rd_val); chk("R11 error flag set", rd_val, 8'hD1);
    wr(0, 8'hD0); send_rx(8'h12, 0, 0, 1, -1, 0);
    rd(0, rd_val); chk("R11 flag survives valid frame", rd_val, 8'hD5);
    fe_sel = 0;
    rd(0, rd_val); chk("R2 bit 7 shows SM0", rd_val, 8'h55);
    fe_sel = 1; wr(0, 8'h50);
    rd(0, rd_val); chk("R11 software clear", rd_val, 8'h50);
    fe_sel = 0;
    rd(0, rd_val); chk("R2 flag write left SM0", rd_val, 8'h50);

    // R9 mode 3 address filter
    wr(0, 8'hF0); send_rx(8'h21, 1, 0, 1, -1, 0);
    rd(0, rd_val); chk("R9 data frame filtered", rd_val, 8'hF0);
    rd(1, rd_val); chk("R9 buffer untouched", rd_val, 8'h12);
    send_rx(8'h42, 1, 1, 1, -1, 0);
    rd(0, rd_val); chk("R9 address frame taken, R8 ninth bit", rd_val, 8'hF5);
    rd(1, rd_val); chk("R9 address byte", rd_val, 8'h42);

    // R9 mode 1 with SM2: bad stop is not accepted, R11 still flags it
    wr(0, 8'h70); send_rx(8'h99, 0, 0, 0, -1, 0);
    rd(0, rd_val); chk("R9 mode 1 bad stop not accepted", rd_val, 8'h70);
    rd(1, rd_val); chk("R9 mode 1 buffer kept", rd_val, 8'h42);
    fe_sel = 1;
    rd(0, rd_val); chk("R11 flag set under SM2", rd_val, 8'hF0);
    wr(0, 8'h70); fe_sel = 0;

    // R12 receiver disabled
    wr(0, 8'h40); send_rx(8'h5E, 0, 0, 1, -1, 0);
    rd(0, rd_val); chk("R12 no RI with REN clear", rd_val, 8'h40);
    rd(1, rd_val); chk("R12 buffer kept with REN clear", rd_val, 8'h42);

    idle(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule